// File: doc/BRIEF.md
# Status Readback Byte Assembler

This block builds the bytes that a two-wire serial slave returns to its host during a read. It sits behind the serial protocol engine. The engine names the byte it is about to send with a small index and strobes a load. The block then freezes that byte in an output register. When the engine reports that the whole byte has been shifted out and acknowledged, it strobes a completion.

Three bytes exist:
- A status byte carrying the live stereo-pilot and adaptive-step indications, two sticky flags and a fixed identifier.
- A level byte.
- A quality byte that packs an ultrasonic-noise value and a wideband-AM value.

The measurements sit in a holding register. A capture strobe refreshes it with live main-frequency data. An alternate-frequency update pulse instead loads a sample and switches the block into sample mode. In sample mode the held values ignore further capture strobes.

The power-on flag and the sample-mode flag both clear as a side effect of a completed read. Each clears only if the byte that was read out actually showed the flag as set. An event arriving during or at the end of that read is therefore never lost.

Top module: `stat_readback`

## Requirements
- R1: Index 0 loads the status byte: bit 7 is pilot_i, bit 6 is step_busy_i (both sampled at the load), bit 5 is the sample-mode flag, bit 4 is the power-on flag, bit 3 is 0, and bits 2:0 are the identifier 3'b100.
- R2: Index 1 loads the held level value (8 bits, 0 to 255). Index 2 loads the held noise value in bits 7:4 and the held AM value in bits 3:0. Index 3 loads 8'h00.
- R3: rd_byte_o takes the addressed byte on the clock edge that samples rd_load_i. It then holds that value unchanged until the next load, whatever the other inputs do. It is 8'h00 after reset.
- R4: The power-on flag is 1 after reset and after any cycle with por_evt_i high. It returns to 0 after rd_done_i completes a status-byte read whose loaded byte showed the flag as 1.
- R5: rd_done_i acts only once, and only on the byte most recently loaded. A load that is never completed, or a completion with no byte in flight, leaves both flags unchanged.
- R6: por_evt_i in the same cycle as the clearing completion keeps the power-on flag set. An event arriving after a status byte that showed 0 was loaded survives that byte's completion.
- R7: With sample mode off, meas_cap_i copies level_i, noise_i and wam_i into the holding register. Without a strobe, the held values do not change.
- R8: af_update_i copies level_i, noise_i and wam_i into the holding register and sets sample mode. While sample mode is on, meas_cap_i has no effect on the held values.
- R9: Sample mode clears after rd_done_i completes an index-2 read whose byte was loaded while sample mode was on. The held values remain until the next meas_cap_i, which again loads live data.
- R10: af_update_i in the same cycle as the clearing completion keeps sample mode on, with the newly sampled values held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| por_evt_i | input | 1 | Register-bank reset event pulse, sets the power-on flag |
| pilot_i | input | 1 | Stereo pilot detected |
| step_busy_i | input | 1 | Adaptive step in progress |
| af_update_i | input | 1 | Alternate-frequency sample pulse |
| meas_cap_i | input | 1 | Live measurement capture strobe |
| level_i | input | 8 | Level measurement |
| noise_i | input | 4 | Ultrasonic-noise measurement |
| wam_i | input | 4 | Wideband-AM measurement |
| rd_idx_i | input | 2 | Index of the byte being loaded |
| rd_load_i | input | 1 | Load addressed byte into the output register |
| rd_done_i | input | 1 | Loaded byte fully shifted and acknowledged |
| rd_byte_o | output | 8 | Byte presented to the serial engine |

## Verification
Suppose the in-flight tracking is wrong, so a stray or repeated completion clears a flag. The next status-byte load then shows bit 4 or bit 5 at 0 where 1 was expected, one cycle after that load.

Suppose the record of what the host saw is wrong, so a flag clears although the host saw 0. Then a power-on or sample event that arrived during a read disappears, and it shows up only at the following status read.

Suppose the holding register is enabled wrongly. Then the level or quality byte shows live values when a sample should be held, or stale values after a capture. This shows on the first load of those indices after the strobe.

// File: rtl/stat_rb_pkg.sv
package stat_rb_pkg;

  typedef enum logic [1:0] {
    IDX_STATUS = 2'd0,
    IDX_LEVEL  = 2'd1,
    IDX_QUAL   = 2'd2,
    IDX_SPARE  = 2'd3
  } rb_idx_e;

  localparam int unsigned RB_IDX_W = $bits(rb_idx_e);

endpackage

// File: rtl/stat_rst_sync.sv
module stat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/stat_sticky.sv
module stat_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic load_i,
  input  logic done_i,
  output logic flag_o
);

  logic flag_q, flag_d;
  logic seen_q, seen_d;

  always_comb begin
    seen_d = seen_q;
    if (load_i) begin
      seen_d = flag_q;
    end
    flag_d = flag_q;
    if (done_i && seen_q) begin
      flag_d = 1'b0;
    end
    if (set_i) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      seen_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      seen_q <= seen_d;
    end
  end

  assign flag_o = flag_q;

  // R6: a set request always wins
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R4: a completed read that showed the flag clears it
  a_r4_clear_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && seen_q && !set_i) |=> !flag_o);

  // R5: without a set and a completion the flag holds
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !done_i) |=> $stable(flag_o));

endmodule

// File: rtl/stat_meas_hold.sv
module stat_meas_hold #(
  parameter int unsigned LEVEL_W = 8,
  parameter int unsigned NOISE_W = 4,
  parameter int unsigned WAM_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic               af_i,
  input  logic               sample_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [NOISE_W-1:0] noise_i,
  input  logic [WAM_W-1:0]   wam_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic [NOISE_W-1:0] noise_o,
  output logic [WAM_W-1:0]   wam_o
);

  logic               take;
  logic [LEVEL_W-1:0] level_q, level_d;
  logic [NOISE_W-1:0] noise_q, noise_d;
  logic [WAM_W-1:0]   wam_q,   wam_d;

  always_comb begin
    take    = af_i | (cap_i & ~sample_i);
    level_d = level_q;
    noise_d = noise_q;
    wam_d   = wam_q;
    if (take) begin
      level_d = level_i;
      noise_d = noise_i;
      wam_d   = wam_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      noise_q <= '0;
      wam_q   <= '0;
    end else begin
      level_q <= level_d;
      noise_q <= noise_d;
      wam_q   <= wam_d;
    end
  end

  assign level_o = level_q;
  assign noise_o = noise_q;
  assign wam_o   = wam_q;

  // R8: a held sample ignores capture strobes
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !af_i) |=> ($stable(level_o) && $stable(noise_o) && $stable(wam_o)));

  // R7: a live capture copies the inputs
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !sample_i) |=> (level_o == $past(level_i) && noise_o == $past(noise_i)
                              && wam_o == $past(wam_i)));

endmodule

// File: rtl/stat_byte_sel.sv
module stat_byte_sel
  import stat_rb_pkg::*;
#(
  parameter int unsigned         LEVEL_W = 8,
  parameter int unsigned         NOISE_W = 4,
  parameter int unsigned         WAM_W   = 4,
  parameter int unsigned         ID_W    = 3,
  parameter logic [ID_W-1:0]     ID_VAL  = 3'b100,
  parameter int unsigned         BYTE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RB_IDX_W-1:0] idx_i,
  input  logic                load_i,
  input  logic                done_i,
  input  logic                pilot_i,
  input  logic                step_i,
  input  logic                sample_i,
  input  logic                por_i,
  input  logic [LEVEL_W-1:0]  level_i,
  input  logic [NOISE_W-1:0]  noise_i,
  input  logic [WAM_W-1:0]    wam_i,
  output logic [BYTE_W-1:0]   byte_o,
  output logic                load_stat_o,
  output logic                load_qual_o,
  output logic                done_stat_o,
  output logic                done_qual_o
);

  logic [BYTE_W-1:0]   byte_q, byte_d, byte_sel;
  logic [RB_IDX_W-1:0] cur_q, cur_d;
  logic                busy_q, busy_d;
  logic                done_ok;

  always_comb begin
    case (rb_idx_e'(idx_i))
      IDX_STATUS: byte_sel = {pilot_i, step_i, sample_i, por_i, 1'b0, ID_VAL};
      IDX_LEVEL:  byte_sel = BYTE_W'(level_i);
      IDX_QUAL:   byte_sel = {noise_i, wam_i};
      default:    byte_sel = '0;
    endcase
  end

  always_comb begin
    done_ok = done_i & busy_q;
    byte_d  = byte_q;
    cur_d   = cur_q;
    busy_d  = busy_q;
    if (done_ok) begin
      busy_d = 1'b0;
    end
    if (load_i) begin
      byte_d = byte_sel;
      cur_d  = idx_i;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      cur_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      byte_q <= byte_d;
      cur_q  <= cur_d;
      busy_q <= busy_d;
    end
  end

  assign byte_o      = byte_q;
  assign load_stat_o = load_i & (idx_i == IDX_STATUS);
  assign load_qual_o = load_i & (idx_i == IDX_QUAL);
  assign done_stat_o = done_ok & (cur_q == IDX_STATUS);
  assign done_qual_o = done_ok & (cur_q == IDX_QUAL);

  // R3: the presented byte only moves on a load
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(byte_o));

  // R1: identifier and reserved bit of the status byte
  a_r1_id_field: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && idx_i == IDX_STATUS) |=> (byte_o[ID_W-1:0] == ID_VAL && !byte_o[ID_W]));

  // R2: spare index reads as zero
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && idx_i == IDX_SPARE) |=> (byte_o == '0));

  // R5: one completion per loaded byte
  a_r5_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_stat_o || done_qual_o) && !load_i) |=> !(done_stat_o || done_qual_o));

endmodule

// File: rtl/stat_readback.sv
module stat_readback
  import stat_rb_pkg::*;
#(
  parameter int unsigned     LEVEL_W     = 8,
  parameter int unsigned     NOISE_W     = 4,
  parameter int unsigned     WAM_W       = 4,
  parameter int unsigned     ID_W        = 3,
  parameter logic [ID_W-1:0] ID_VAL      = 3'b100,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                por_evt_i,
  input  logic                pilot_i,
  input  logic                step_busy_i,
  input  logic                af_update_i,
  input  logic                meas_cap_i,
  input  logic [LEVEL_W-1:0]  level_i,
  input  logic [NOISE_W-1:0]  noise_i,
  input  logic [WAM_W-1:0]    wam_i,
  input  logic [RB_IDX_W-1:0] rd_idx_i,
  input  logic                rd_load_i,
  input  logic                rd_done_i,
  output logic [LEVEL_W-1:0]  rd_byte_o
);

  localparam int unsigned BYTE_W = LEVEL_W;

  logic               rst_n;
  logic               por_flag, sample_flag;
  logic               load_stat, load_qual, done_stat, done_qual;
  logic [LEVEL_W-1:0] h_level;
  logic [NOISE_W-1:0] h_noise;
  logic [WAM_W-1:0]   h_wam;

  stat_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  stat_sticky #(.RST_VAL(1'b1)) u_por (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (por_evt_i),
    .load_i (load_stat),
    .done_i (done_stat),
    .flag_o (por_flag)
  );

  stat_sticky #(.RST_VAL(1'b0)) u_samp (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (af_update_i),
    .load_i (load_qual),
    .done_i (done_qual),
    .flag_o (sample_flag)
  );

  stat_meas_hold #(
    .LEVEL_W (LEVEL_W),
    .NOISE_W (NOISE_W),
    .WAM_W   (WAM_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_i    (meas_cap_i),
    .af_i     (af_update_i),
    .sample_i (sample_flag),
    .level_i  (level_i),
    .noise_i  (noise_i),
    .wam_i    (wam_i),
    .level_o  (h_level),
    .noise_o  (h_noise),
    .wam_o    (h_wam)
  );

  stat_byte_sel #(
    .LEVEL_W (LEVEL_W),
    .NOISE_W (NOISE_W),
    .WAM_W   (WAM_W),
    .ID_W    (ID_W),
    .ID_VAL  (ID_VAL),
    .BYTE_W  (BYTE_W)
  ) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_i       (rd_idx_i),
    .load_i      (rd_load_i),
    .done_i      (rd_done_i),
    .pilot_i     (pilot_i),
    .step_i      (step_busy_i),
    .sample_i    (sample_flag),
    .por_i       (por_flag),
    .level_i     (h_level),
    .noise_i     (h_noise),
    .wam_i       (h_wam),
    .byte_o      (rd_byte_o),
    .load_stat_o (load_stat),
    .load_qual_o (load_qual),
    .done_stat_o (done_stat),
    .done_qual_o (done_qual)
  );

  // R10: an update at the clearing completion keeps sample mode
  a_r10_af_wins: assert property (@(posedge clk) disable iff (!rst_n)
    af_update_i |=> sample_flag);

  // R9: a completed sampled quality read ends sample mode
  a_r9_samp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_qual) && !af_update_i && sample_flag && $past(load_qual) && $past(sample_flag))
      |=> !sample_flag);

endmodule

// File: tb/sim_stat_readback.sv
`timescale 1ns/1ps
module sim_stat_readback;

  logic       clk = 1'b0;
  logic       rst_ni, por_evt, pilot, step, af_upd, cap, rd_load, rd_done;
  logic [7:0] level, rd_byte;
  logic [3:0] noise, wam;
  logic [1:0] rd_idx;
  logic       load_seen;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  stat_readback u0 (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .por_evt_i   (por_evt),
    .pilot_i     (pilot),
    .step_busy_i (step),
    .af_update_i (af_upd),
    .meas_cap_i  (cap),
    .level_i     (level),
    .noise_i     (noise),
    .wam_i       (wam),
    .rd_idx_i    (rd_idx),
    .rd_load_i   (rd_load),
    .rd_done_i   (rd_done),
    .rd_byte_o   (rd_byte)
  );

  // monitor: compares the byte one half cycle after the sampling edge
  always @(posedge clk) load_seen <= rd_load;

  always @(negedge clk) begin
    if (load_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected load got %02h exp none", rd_byte);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rd_byte !== e) begin
          errors++;
          $display("FAIL %s got %02h exp %02h", t, rd_byte, e);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] idx, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_idx  = idx;
    rd_load = 1'b1;
    @(negedge clk);
    rd_load = 1'b0;
  endtask

  task automatic fin(input logic p, input logic a);
    @(negedge clk);
    rd_done = 1'b1;
    por_evt = p;
    af_upd  = a;
    @(negedge clk);
    rd_done = 1'b0;
    por_evt = 1'b0;
    af_upd  = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) por_evt = 1'b1;
    if (which == 1) af_upd  = 1'b1;
    if (which == 2) cap     = 1'b1;
    @(negedge clk);
    por_evt = 1'b0;
    af_upd  = 1'b0;
    cap     = 1'b0;
  endtask

  task automatic set_meas(input logic [7:0] l, input logic [3:0] n, input logic [3:0] w);
    level = l;
    noise = n;
    wam   = w;
  endtask

  task automatic chk(input logic [7:0] e, input string t);
    checks++;
    if (rd_byte !== e) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", t, rd_byte, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got hang exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; por_evt = 1'b0; pilot = 1'b0; step = 1'b0; af_upd = 1'b0;
    cap = 1'b0; rd_load = 1'b0; rd_done = 1'b0; rd_idx = 2'd0;
    set_meas(8'h00, 4'h0, 4'h0);
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(8'h00, "R3 reset value");

    // R1 / R4: power-on flag visible, then cleared by a completed read
    rd(2'd0, 8'h14, "R4 por after reset");
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h04, "R4 por cleared");
    fin(1'b0, 1'b0);
    pilot = 1'b1; step = 1'b1;
    rd(2'd0, 8'hC4, "R1 pilot and step bits");
    fin(1'b0, 1'b0);
    pilot = 1'b0; step = 1'b0;

    // R5: aborted read and stray completion
    pulse(0);
    rd(2'd0, 8'h14, "R5 por set by event");
    rd(2'd1, 8'h00, "R2 level before capture");
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h14, "R5 aborted read keeps por");
    fin(1'b0, 1'b0);
    pulse(0);
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h14, "R5 stray done ignored");
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h04, "R4 cleared again");
    fin(1'b0, 1'b0);

    // R6: event priority and event during a read
    pulse(0);
    rd(2'd0, 8'h14, "R6 setup");
    fin(1'b1, 1'b0);
    rd(2'd0, 8'h14, "R6 same-cycle event wins");
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h04, "R6 read shows zero");
    pulse(0);
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h14, "R6 event during read kept");
    fin(1'b0, 1'b0);

    // R7 / R2: live capture and byte packing
    set_meas(8'h5A, 4'h3, 4'hC);
    pulse(2);
    set_meas(8'hEE, 4'hF, 4'hF);
    rd(2'd1, 8'h5A, "R7 level captured");
    fin(1'b0, 1'b0);
    rd(2'd2, 8'h3C, "R2 noise high AM low");
    fin(1'b0, 1'b0);
    rd(2'd3, 8'h00, "R2 spare index");
    fin(1'b0, 1'b0);

    // R3: byte frozen while inputs and capture move
    rd(2'd1, 8'h5A, "R3 load level");
    set_meas(8'h33, 4'h1, 4'h1);
    pilot = 1'b1;
    pulse(2);
    repeat (3) @(negedge clk);
    chk(8'h5A, "R3 byte frozen during shift");
    fin(1'b0, 1'b0);
    pilot = 1'b0;
    rd(2'd2, 8'h11, "R7 second capture");
    fin(1'b0, 1'b0);

    // R8 / R9: sample mode
    set_meas(8'hA7, 4'h9, 4'h1);
    pulse(1);
    set_meas(8'h11, 4'h2, 4'h2);
    pulse(2);
    rd(2'd0, 8'h24, "R8 sample bit set");
    fin(1'b0, 1'b0);
    rd(2'd1, 8'hA7, "R8 capture ignored while sampled");
    fin(1'b0, 1'b0);
    rd(2'd2, 8'h91, "R8 sampled quality");
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h04, "R9 sample bit cleared");
    fin(1'b0, 1'b0);
    rd(2'd1, 8'hA7, "R9 held until capture");
    fin(1'b0, 1'b0);
    pulse(2);
    rd(2'd1, 8'h11, "R9 live data resumes");
    fin(1'b0, 1'b0);

    // R10: update at the clearing completion
    set_meas(8'hB0, 4'h5, 4'h6);
    pulse(1);
    rd(2'd2, 8'h56, "R10 first sample");
    set_meas(8'hC0, 4'h7, 4'h8);
    fin(1'b0, 1'b1);
    rd(2'd0, 8'h24, "R10 sample mode kept");
    fin(1'b0, 1'b0);
    rd(2'd1, 8'hC0, "R10 new sample held");
    fin(1'b0, 1'b0);
    rd(2'd2, 8'h78, "R10 new sample quality");
    fin(1'b0, 1'b0);
    rd(2'd0, 8'h04, "R9 cleared after new sample read");
    fin(1'b0, 1'b0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 pending loads got %0d exp 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule